// File: doc/BRIEF.md
# Iterative Divide Unit with Condition Flags

This block divides a 32-bit dividend by a divisor one quotient bit per clock. It delivers a quotient, a remainder and three condition flags: zero, sign and overflow. A two-bit mode input picks one of four variants. The divisor is either a full-width signed or unsigned operand, or the low half of the divisor bus, sign- or zero-extended.

A pipeline pulses `start` with its operands while the unit is idle. The unit raises `busy` while it iterates, then pulses `done` for one cycle together with `wb_en`. The register file writes `quotient` back to the dividend's register and `remainder` to a separate third register only when `wb_en` is high. The flags are refreshed at every `done`.

Top module: `divflag_unit`

## Requirements
- R1: Mode 0 (signed, full divisor): the quotient truncates toward zero. The remainder is zero or carries the sign of the dividend, and dividend = quotient*divisor + remainder.
- R2: Mode 1 (unsigned, full divisor): both operands are treated as unsigned 32-bit values.
- R3: Mode 2 (signed, half divisor): the divisor is bits 15:0 of `divisor`, sign-extended to 32 bits. Bits 31:16 have no effect on the result.
- R4: Mode 3 (unsigned, half divisor): the divisor is bits 15:0 of `divisor`, zero-extended. Bits 31:16 have no effect on the result.
- R5: When the effective divisor is zero, `done` comes with `wb_en` low and `flag_ovf` set, with `flag_zero` and `flag_sign` cleared. `quotient` and `remainder` keep their previous values.
- R6: In a signed mode, a dividend of 0x80000000 with an effective divisor of -1 sets `flag_ovf`, writes quotient 0x80000000 and remainder 0, and raises `wb_en`.
- R7: At every `done` all three flags are first cleared. Each is then set from this result: zero when the quotient is 0, and sign equal to quotient bit 31 in every mode. Overflow is clear for every divide other than those of R5 and R6.
- R8: A `start` is taken only while `busy` is low. `busy` is high from the edge that takes the start until `done` rises. `done` rises 33 clock edges after the accepting edge and lasts one cycle, with `busy` low. A `start` while busy is ignored.
- R9: After reset `busy`, `done` and `wb_en` are 0, `quotient` and `remainder` are 0, and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a divide with the present operands |
| mode | input | 2 | 0 signed full, 1 unsigned full, 2 signed half, 3 unsigned half |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand (low half used in modes 2 and 3) |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Quotient and remainder are to be written back |
| quotient | output | 32 | Quotient of the last written divide |
| remainder | output | 32 | Remainder of the last written divide |
| flag_zero | output | 1 | Quotient equal to zero |
| flag_sign | output | 1 | Quotient bit 31 |
| flag_ovf | output | 1 | Zero divisor or signed overflow |

## Verification
The bench builds the unit with its default widths of 32 and 16. With those widths the most negative dividend 0x80000000 and half-word divisor patterns such as 0xFFFF can be driven directly. That makes the signed overflow case reachable in both the full and the half modes. It also lets the bench put junk in the upper divisor half and show that the half modes ignore it. Latency, back-to-back starts and starts while busy are compared cycle by cycle against a behavioural model.

// File: rtl/divflag_pkg.sv
package divflag_pkg;

    typedef enum logic [1:0] {
        MODE_S_FULL = 2'd0,
        MODE_U_FULL = 2'd1,
        MODE_S_HALF = 2'd2,
        MODE_U_HALF = 2'd3
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_e;

    typedef struct packed {
        logic v;
        logic s;
        logic z;
    } cc_t;

    typedef struct packed {
        logic neg_q;
        logic neg_r;
        logic div_zero;
        logic ovf_min;
    } div_ctl_t;

    function automatic logic mode_is_signed(div_mode_e m);
        return (m == MODE_S_FULL) || (m == MODE_S_HALF);
    endfunction

    function automatic logic mode_is_half(div_mode_e m);
        return (m == MODE_S_HALF) || (m == MODE_U_HALF);
    endfunction

endpackage

// File: rtl/divflag_prep.sv
module divflag_prep
    import divflag_pkg::*;
#(
    parameter int W = 32,
    parameter int H = 16
) (
    input  div_mode_e       mode,
    input  logic [W-1:0]    num_in,
    input  logic [W-1:0]    den_in,
    output logic [W-1:0]    num_mag,
    output logic [W-1:0]    den_mag,
    output div_ctl_t        ctl
);
    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
    localparam int           XW      = W - H;

    logic [W-1:0] den_ext;
    logic         sgn;
    logic         sa;
    logic         sb;

    always_comb begin
        sgn = mode_is_signed(mode);
        if (mode_is_half(mode)) begin
            if (sgn) den_ext = {{XW{den_in[H-1]}}, den_in[H-1:0]};
            else     den_ext = {{XW{1'b0}}, den_in[H-1:0]};
        end else begin
            den_ext = den_in;
        end
        sa = sgn & num_in[W-1];
        sb = sgn & den_ext[W-1];
        num_mag = sa ? (~num_in + 1'b1) : num_in;
        den_mag = sb ? (~den_ext + 1'b1) : den_ext;
        ctl.neg_q    = sa ^ sb;
        ctl.neg_r    = sa;
        ctl.div_zero = (den_ext == '0);
        ctl.ovf_min  = sgn && (num_in == MIN_VAL) && (den_ext == '1);
    end

endmodule

// File: rtl/divflag_core.sv
module divflag_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] q_mag,
    output logic [W-1:0] r_mag
);
    logic [W:0]   acc;
    logic [W-1:0] quo;
    logic [W-1:0] den_r;
    logic [W:0]   shifted;
    logic [W:0]   diff;

    always_comb begin
        shifted = {acc[W-1:0], quo[W-1]};
        diff    = shifted - {1'b0, den_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            quo   <= '0;
            den_r <= '0;
        end else if (load) begin
            acc   <= '0;
            quo   <= num;
            den_r <= den;
        end else if (step) begin
            if (!diff[W]) begin
                acc <= diff;
                quo <= {quo[W-2:0], 1'b1};
            end else begin
                acc <= shifted;
                quo <= {quo[W-2:0], 1'b0};
            end
        end
    end

    assign q_mag = quo;
    assign r_mag = acc[W-1:0];

    // R1: partial remainder stays below a non-zero divisor
    p_rem_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (den_r != '0) |-> (acc < {1'b0, den_r}));

endmodule

// File: rtl/divflag_fix.sv
module divflag_fix
    import divflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  div_ctl_t     ctl,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output cc_t          cc
);
    always_comb begin
        q_out = ctl.neg_q ? (~q_mag + 1'b1) : q_mag;
        r_out = ctl.neg_r ? (~r_mag + 1'b1) : r_mag;
        cc    = '0;
        cc.v  = ctl.div_zero | ctl.ovf_min;
        if (!ctl.div_zero) begin
            cc.z = (q_out == '0);
            cc.s = q_out[W-1];
        end
    end

endmodule

// File: rtl/divflag_unit.sv
module divflag_unit
    import divflag_pkg::*;
#(
    parameter int W = 32,
    parameter int H = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         wb_en,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         flag_zero,
    output logic         flag_sign,
    output logic         flag_ovf
);
    localparam int           CW      = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS  = CW'(W);
    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

    seq_e         state;
    logic [CW-1:0] cnt;
    logic         accept;
    div_ctl_t     ctl_now;
    div_ctl_t     ctl_r;
    logic [W-1:0] num_mag;
    logic [W-1:0] den_mag;
    logic [W-1:0] q_mag;
    logic [W-1:0] r_mag;
    logic [W-1:0] q_fix;
    logic [W-1:0] r_fix;
    cc_t          cc_fix;
    cc_t          cc_r;
    logic [W-1:0] q_r;
    logic [W-1:0] r_r;
    logic         done_r;
    logic         wb_r;

    assign accept = start && (state == ST_IDLE);

    divflag_prep #(.W(W), .H(H)) u_prep (
        .mode    (div_mode_e'(mode)),
        .num_in  (dividend),
        .den_in  (divisor),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .ctl     (ctl_now)
    );

    divflag_core #(.W(W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .step  (state == ST_RUN),
        .num   (num_mag),
        .den   (den_mag),
        .q_mag (q_mag),
        .r_mag (r_mag)
    );

    divflag_fix #(.W(W)) u_fix (
        .q_mag (q_mag),
        .r_mag (r_mag),
        .ctl   (ctl_r),
        .q_out (q_fix),
        .r_out (r_fix),
        .cc    (cc_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            ctl_r  <= '0;
            cc_r   <= '0;
            q_r    <= '0;
            r_r    <= '0;
            done_r <= 1'b0;
            wb_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            wb_r   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_r <= ctl_now;
                        cnt   <= STEPS;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CW'(1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    done_r <= 1'b1;
                    cc_r   <= cc_fix;
                    if (!ctl_r.div_zero) begin
                        wb_r <= 1'b1;
                        q_r  <= q_fix;
                        r_r  <= r_fix;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = done_r;
    assign wb_en     = wb_r;
    assign quotient  = q_r;
    assign remainder = r_r;
    assign flag_zero = cc_r.z;
    assign flag_sign = cc_r.s;
    assign flag_ovf  = cc_r.v;

    // R8: completion pulse is one cycle and comes with busy low
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R5: zero divisor leaves results untouched and flags overflow
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !wb_en) |-> ($stable(quotient) && $stable(remainder) && flag_ovf
                              && !flag_zero && !flag_sign));
    // R7: zero and sign flags follow the written quotient
    p_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (done && wb_en) |-> ((flag_zero == (quotient == '0)) && (flag_sign == quotient[W-1])));
    // R6: a written result with overflow is the wrapped most negative quotient
    p_min_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        (done && wb_en && flag_ovf) |-> ((quotient == MIN_VAL) && (remainder == '0)));

endmodule

// File: tb/tb_divflag_unit.sv
module tb_divflag_unit;
    localparam int W = 32;
    localparam int H = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   mode;
    logic [W-1:0] dividend;
    logic [W-1:0] divisor;
    logic         busy, done, wb_en, flag_zero, flag_sign, flag_ovf;
    logic [W-1:0] quotient, remainder;

    int n_chk = 0;
    int n_err = 0;
    logic finished = 1'b0;

    // behavioural reference model state
    bit        m_busy = 0, m_done = 0, m_wb = 0;
    int        m_cnt = 0;
    bit [31:0] m_q = 0, m_r = 0;
    bit        m_z = 0, m_s = 0, m_v = 0;
    bit [1:0]  c_mode;
    bit [31:0] c_a, c_b;
    string     c_tag = "R9";

    divflag_unit #(.W(W), .H(H)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .wb_en(wb_en),
        .quotient(quotient), .remainder(remainder),
        .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_ovf(flag_ovf)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model_finish();
        longint a, b, q, r;
        bit sgn = (c_mode == 2'd0) || (c_mode == 2'd2);
        if (c_mode == 2'd2)      b = longint'($signed(c_b[15:0]));
        else if (c_mode == 2'd3) b = longint'(c_b[15:0]);
        else if (sgn)            b = longint'($signed(c_b));
        else                     b = longint'(c_b);
        a = sgn ? longint'($signed(c_a)) : longint'(c_a);
        m_z = 0; m_s = 0; m_v = 0;
        if (b == 0) begin
            m_v = 1; m_wb = 0;
        end else begin
            q = a / b;
            r = a % b;
            if (sgn && a == -64'sd2147483648 && b == -1) m_v = 1;
            m_q = q[31:0];
            m_r = r[31:0];
            m_z = (m_q == 0);
            m_s = m_q[31];
            m_wb = 1;
        end
    endfunction

    function automatic void model_step();
        bit acc = start && !m_busy;
        m_done = 0;
        m_wb = 0;
        if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 0;
                m_done = 1;
                model_finish();
            end
        end
        if (acc) begin
            m_busy = 1;
            m_cnt = W + 1;
            c_mode = mode; c_a = dividend; c_b = divisor;
        end
    endfunction

    task automatic compare();
        chk("R8", "busy", 64'(busy), 64'(m_busy));
        chk("R8", "done", 64'(done), 64'(m_done));
        chk(c_tag, "wb_en", 64'(wb_en), 64'(m_wb));
        chk(c_tag, "quotient", 64'(quotient), 64'(m_q));
        chk(c_tag, "remainder", 64'(remainder), 64'(m_r));
        chk((m_done && !m_v) ? "R7" : c_tag, "flags",
            64'({flag_zero, flag_sign, flag_ovf}), 64'({m_z, m_s, m_v}));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run_op(input string tag, input bit [1:0] md,
                          input bit [31:0] a, input bit [31:0] b);
        c_tag = tag;
        start = 1'b1; mode = md; dividend = a; divisor = b;
        tick();
        start = 1'b0;
        while (m_busy) tick();
        tick();
    endtask

    initial begin
        #4000000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = 2'd0; dividend = '0; divisor = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        compare();
        chk("R9", "reset q/r", 64'({quotient, remainder}), 64'd0);

        run_op("R1", 2'd0, 32'd7, 32'hFFFF_FFFE);          // 7 / -2 = -3 r 1
        run_op("R1", 2'd0, 32'hFFFF_FFF9, 32'd2);          // -7 / 2 = -3 r -1
        run_op("R1", 2'd0, 32'hFFFF_FF9C, 32'hFFFF_FFF9);  // -100 / -7
        run_op("R2", 2'd1, 32'hFFFF_FFFF, 32'd3);
        run_op("R2", 2'd1, 32'h8000_0000, 32'd1);          // sign flag from bit 31
        run_op("R3", 2'd2, 32'd100, 32'hABCD_FFF6);        // divisor -10
        run_op("R4", 2'd3, 32'd100000, 32'h1234_FFF6);     // divisor 65526
        run_op("R4", 2'd3, 32'h8000_0000, 32'hDEAD_FFFF);  // no overflow unsigned
        run_op("R7", 2'd1, 32'd3, 32'd7);                  // zero quotient
        run_op("R5", 2'd0, 32'd55, 32'd0);
        run_op("R5", 2'd2, 32'd55, 32'hFFFF_0000);         // half divisor zero
        run_op("R6", 2'd0, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R6", 2'd2, 32'h8000_0000, 32'h0000_FFFF);

        // R8: back-to-back start in the done cycle, and a start while busy
        c_tag = "R8";
        start = 1'b1; mode = 2'd1; dividend = 32'd1000; divisor = 32'd9;
        tick();
        start = 1'b0;
        repeat (5) tick();
        start = 1'b1; dividend = 32'd1; divisor = 32'd0;   // ignored while busy
        tick();
        start = 1'b0;
        while (!m_done) tick();
        start = 1'b1; mode = 2'd0; dividend = 32'hFFFF_F000; divisor = 32'd16;
        tick();
        start = 1'b0;
        while (m_busy) tick();
        tick();
        tick();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule